// File: doc/BRIEF.md
# Receive Mailbox Lock Coherency Controller

This block keeps CPU accesses to a bank of receive mailboxes coherent with the hardware that copies frames into them from a serial receive buffer. When the CPU reads a mailbox's control word, that mailbox becomes locked. A frame that the receive side wants to move into a locked mailbox waits in the serial buffer until the lock is gone. Only one mailbox can hold the lock at a time. The lock follows the most recent control-word read. Reading the free-running timer drops the lock, and so does deactivating the locked mailbox.

A move-in copies a fixed number of words into one mailbox, one word per cycle. If the CPU reads the control word of the mailbox that is being filled, the returned code has its busy bit set and the lock stays where it was. The CPU can disturb a move in two ways. Deactivating the target mailbox aborts the move and leaves the mailbox inactive, holding a mix of old and new words. Writing one of its data words also aborts the move, but the mailbox state still advances to full or overrun. Neither abort raises the completion pulse. A pending frame whose target mailbox is inactive is dropped instead of being moved.

Top module: `rxmb_guard`

## Requirements
- R1: After reset no lock is held, no move runs, the returned code is 0, and every mailbox is empty. Mailbox states are encoded as 00 empty, 01 full, 10 overrun and 11 inactive.
- R2: A control-word read of a mailbox that is not being moved makes it the locked mailbox from the next cycle. The code returned in that next cycle is {state[1:0], busy}, where busy is bit 0.
- R3: At most one mailbox is locked. A control-word read of a different mailbox moves the lock to it.
- R4: A timer read clears any lock from the next cycle. This takes priority over a control-word read in the same cycle.
- R5: A control-word read of the mailbox under move returns a code with bit 0 set in the next cycle, and the lock does not change.
- R6: A move-in request whose target is locked, or is being read or deactivated in that cycle, is not accepted. It is accepted in the first cycle after the lock is released.
- R7: An accepted move writes words 0 to WORDS-1 to the target on consecutive cycles, starting the cycle after acceptance. The completion pulse follows one cycle after the last word.
- R8: A completed move turns an empty mailbox into full, and a full or overrun mailbox into overrun.
- R9: Deactivating the target during a move stops the word writes and gives an abort pulse in the next cycle with no completion pulse. The mailbox becomes inactive.
- R10: A CPU data write to the target during a move aborts it as in R9, except that the state still advances as in R8.
- R11: Deactivating the locked mailbox clears the lock. A request held for it is then dropped with a drop pulse, and nothing is written.
- R12: Re-arming a mailbox sets it empty and active, so that a later request for it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_idx | input | IDX_W | Mailbox addressed by the CPU strobe |
| cpu_ctrl_rd | input | 1 | CPU reads the mailbox control word |
| cpu_tmr_rd | input | 1 | CPU reads the free-running timer |
| cpu_deact | input | 1 | CPU deactivates the mailbox |
| cpu_arm | input | 1 | CPU re-arms the mailbox as empty |
| cpu_data_wr | input | 1 | CPU writes a data word of the mailbox |
| cpu_code | output | 3 | Code from the last control read: {state, busy} |
| lock_vld | output | 1 | A mailbox is locked |
| lock_idx | output | IDX_W | Locked mailbox |
| rx_req | input | 1 | A frame waits in the serial buffer |
| rx_idx | input | IDX_W | Target mailbox of the waiting frame |
| rx_ack | output | 1 | Frame accepted for move-in (this cycle) |
| rx_drop | output | 1 | Frame discarded, target inactive (this cycle) |
| mv_we | output | 1 | Word write strobe into the mailbox |
| mv_word | output | WC_W | Word number being written |
| mv_idx | output | IDX_W | Mailbox being filled |
| mv_done | output | 1 | Move completed (interrupt event) |
| mv_abort | output | 1 | Move aborted, no interrupt |

## Verification
The lock path is exercised first by a vector table of reads, timer reads, deactivations and re-arms with no traffic. This separates the lock moving, the lock being released, and an unrelated mailbox being touched. Moves are then run into an empty mailbox, a full one and a locked one, which shows the state advancing and shows a request being held back and then accepted. The run ends with collisions between the CPU and a move: a read during the move, which must return busy and leave the lock alone, and a deactivation or a data write during the move, which must abort without completion but update the state differently. A deactivation of a locked mailbox with a frame pending must drop that frame.

// File: rtl/rxmb_guard_pkg.sv
// Package: shared mailbox state encoding and state-advance rule.
// Assumes: two-bit state field visible to the CPU in the returned code.
package rxmb_guard_pkg;

    typedef enum logic [1:0] {
        MB_EMPTY = 2'b00,
        MB_FULL  = 2'b01,
        MB_OVRN  = 2'b10,
        MB_OFF   = 2'b11
    } mb_state_e;

    localparam int CODE_W = 3;

    // State after a frame lands in a mailbox.
    function automatic mb_state_e fill_next(input mb_state_e cur);
        return (cur == MB_EMPTY) ? MB_FULL : MB_OVRN;
    endfunction

endpackage

// File: rtl/rxmb_status_array.sv
// Module: per-mailbox state register (empty/full/overrun/inactive).
// Assumes: NUM_MB is a power of two; at most one CPU strobe per cycle.
// Priority per mailbox: deactivate, then fill, then re-arm.
module rxmb_status_array
    import rxmb_guard_pkg::*;
#(
    parameter int NUM_MB = 16,
    localparam int IDX_W = $clog2(NUM_MB)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] cpu_idx,
    input  logic             deact_i,
    input  logic             arm_i,
    input  logic             fill_i,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [IDX_W-1:0] rx_idx,
    output mb_state_e        cpu_st,
    output mb_state_e        rx_st
);

    logic [1:0] st_all [NUM_MB];

    for (genvar g = 0; g < NUM_MB; g++) begin : g_mb
        mb_state_e st_q;

        // Update this mailbox's state from CPU and fill events.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q <= MB_EMPTY;
            end else if (deact_i && cpu_idx == IDX_W'(g)) begin
                st_q <= MB_OFF;
            end else if (fill_i && fill_idx == IDX_W'(g)) begin
                st_q <= fill_next(st_q);
            end else if (arm_i && cpu_idx == IDX_W'(g)) begin
                st_q <= MB_EMPTY;
            end
        end

        assign st_all[g] = st_q;
    end

    // Select the states seen by the CPU port and the receive side.
    always_comb begin
        cpu_st = mb_state_e'(st_all[cpu_idx]);
        rx_st  = mb_state_e'(st_all[rx_idx]);
    end

endmodule

// File: rtl/rxmb_lock_tracker.sv
// Module: single-entry lock register.
// Assumes: one CPU strobe per cycle. Priority: deactivate of the locked
// mailbox, then timer read, then a control read that is not busy.
module rxmb_lock_tracker #(
    parameter int NUM_MB = 16,
    localparam int IDX_W = $clog2(NUM_MB)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] cpu_idx,
    input  logic             ctrl_rd_i,
    input  logic             tmr_rd_i,
    input  logic             deact_i,
    input  logic             busy_hit_i,
    output logic             lock_vld_o,
    output logic [IDX_W-1:0] lock_idx_o
);

    // Move, set or release the lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_vld_o <= 1'b0;
            lock_idx_o <= '0;
        end else if (deact_i && lock_vld_o && cpu_idx == lock_idx_o) begin
            lock_vld_o <= 1'b0;
        end else if (tmr_rd_i) begin
            lock_vld_o <= 1'b0;
        end else if (ctrl_rd_i && !busy_hit_i) begin
            lock_vld_o <= 1'b1;
            lock_idx_o <= cpu_idx;
        end
    end

endmodule

// File: rtl/rxmb_move_engine.sv
// Module: move-in sequencer from the serial buffer into one mailbox.
// Assumes: WORDS >= 2; the receive side holds rx_req until ack or drop.
// A move runs WORDS cycles after acceptance and can be aborted by the CPU.
module rxmb_move_engine #(
    parameter int NUM_MB = 16,
    parameter int WORDS  = 4,
    localparam int IDX_W = $clog2(NUM_MB),
    localparam int WC_W  = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_req,
    input  logic [IDX_W-1:0] rx_idx,
    input  logic             tgt_active,
    input  logic             lock_vld,
    input  logic [IDX_W-1:0] lock_idx,
    input  logic [IDX_W-1:0] cpu_idx,
    input  logic             cpu_ctrl_rd,
    input  logic             cpu_deact,
    input  logic             cpu_data_wr,
    output logic             rx_ack,
    output logic             rx_drop,
    output logic             active_o,
    output logic [IDX_W-1:0] mv_idx_o,
    output logic [WC_W-1:0]  mv_word_o,
    output logic             mv_we_o,
    output logic             fill_o,
    output logic             mv_done_o,
    output logic             mv_abort_o
);

    logic             active_q;
    logic [IDX_W-1:0] idx_q;
    logic [WC_W-1:0]  cnt_q;
    logic             blocked, hit, ab_deact, ab_wr, ab_any, last, fin;

    // Acceptance decision and abort/finish detection for this cycle.
    always_comb begin
        blocked  = (lock_vld && lock_idx == rx_idx)
                 || ((cpu_ctrl_rd || cpu_deact) && cpu_idx == rx_idx);
        rx_drop  = !active_q && rx_req && !tgt_active;
        rx_ack   = !active_q && rx_req && tgt_active && !blocked;
        hit      = active_q && cpu_idx == idx_q;
        ab_deact = hit && cpu_deact;
        ab_wr    = hit && cpu_data_wr && !cpu_deact;
        ab_any   = ab_deact || ab_wr;
        last     = active_q && cnt_q == WC_W'(WORDS - 1);
        fin      = last && !ab_any;
        mv_we_o  = active_q && !ab_any;
        fill_o   = fin || ab_wr;
    end

    // Sequence the word counter across one move.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            idx_q    <= '0;
            cnt_q    <= '0;
        end else if (rx_ack) begin
            active_q <= 1'b1;
            idx_q    <= rx_idx;
            cnt_q    <= '0;
        end else if (active_q) begin
            if (ab_any || last) begin
                active_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Register the completion and abort events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mv_done_o  <= 1'b0;
            mv_abort_o <= 1'b0;
        end else begin
            mv_done_o  <= fin;
            mv_abort_o <= ab_any;
        end
    end

    assign active_o  = active_q;
    assign mv_idx_o  = idx_q;
    assign mv_word_o = cnt_q;

endmodule

// File: rtl/rxmb_guard.sv
// Module: top of the receive mailbox lock coherency controller.
// Assumes: the CPU issues at most one strobe per cycle; frame matching
// happens upstream and delivers only a target mailbox index.
module rxmb_guard
    import rxmb_guard_pkg::*;
#(
    parameter int NUM_MB = 16,
    parameter int WORDS  = 4,
    localparam int IDX_W = $clog2(NUM_MB),
    localparam int WC_W  = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  cpu_idx,
    input  logic              cpu_ctrl_rd,
    input  logic              cpu_tmr_rd,
    input  logic              cpu_deact,
    input  logic              cpu_arm,
    input  logic              cpu_data_wr,
    output logic [CODE_W-1:0] cpu_code,
    output logic              lock_vld,
    output logic [IDX_W-1:0]  lock_idx,
    input  logic              rx_req,
    input  logic [IDX_W-1:0]  rx_idx,
    output logic              rx_ack,
    output logic              rx_drop,
    output logic              mv_we,
    output logic [WC_W-1:0]   mv_word,
    output logic [IDX_W-1:0]  mv_idx,
    output logic              mv_done,
    output logic              mv_abort
);

    mb_state_e cpu_st, rx_st;
    logic      mv_active, fill, busy_hit;

    assign busy_hit = mv_active && mv_idx == cpu_idx;

    rxmb_status_array #(.NUM_MB(NUM_MB)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_idx  (cpu_idx),
        .deact_i  (cpu_deact),
        .arm_i    (cpu_arm),
        .fill_i   (fill),
        .fill_idx (mv_idx),
        .rx_idx   (rx_idx),
        .cpu_st   (cpu_st),
        .rx_st    (rx_st)
    );

    rxmb_lock_tracker #(.NUM_MB(NUM_MB)) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_idx    (cpu_idx),
        .ctrl_rd_i  (cpu_ctrl_rd),
        .tmr_rd_i   (cpu_tmr_rd),
        .deact_i    (cpu_deact),
        .busy_hit_i (busy_hit),
        .lock_vld_o (lock_vld),
        .lock_idx_o (lock_idx)
    );

    rxmb_move_engine #(.NUM_MB(NUM_MB), .WORDS(WORDS)) u_move (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_req      (rx_req),
        .rx_idx      (rx_idx),
        .tgt_active  (rx_st != MB_OFF),
        .lock_vld    (lock_vld),
        .lock_idx    (lock_idx),
        .cpu_idx     (cpu_idx),
        .cpu_ctrl_rd (cpu_ctrl_rd),
        .cpu_deact   (cpu_deact),
        .cpu_data_wr (cpu_data_wr),
        .rx_ack      (rx_ack),
        .rx_drop     (rx_drop),
        .active_o    (mv_active),
        .mv_idx_o    (mv_idx),
        .mv_word_o   (mv_word),
        .mv_we_o     (mv_we),
        .fill_o      (fill),
        .mv_done_o   (mv_done),
        .mv_abort_o  (mv_abort)
    );

    // Latch the code returned to a control-word read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_code <= '0;
        end else if (cpu_ctrl_rd) begin
            cpu_code <= {cpu_st, busy_hit};
        end
    end

endmodule

// File: rtl/rxmb_guard_chk.sv
// Module: assertion checker for rxmb_guard, attached by bind below.
// Assumes: it observes the top ports plus the move-active and busy nets.
module rxmb_guard_chk #(
    parameter int NUM_MB = 16,
    parameter int WORDS  = 4,
    localparam int IDX_W = $clog2(NUM_MB),
    localparam int WC_W  = $clog2(WORDS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [IDX_W-1:0] cpu_idx,
    input logic             cpu_ctrl_rd,
    input logic             cpu_tmr_rd,
    input logic             cpu_deact,
    input logic             cpu_data_wr,
    input logic [2:0]       cpu_code,
    input logic             lock_vld,
    input logic [IDX_W-1:0] lock_idx,
    input logic [IDX_W-1:0] rx_idx,
    input logic             rx_ack,
    input logic             rx_drop,
    input logic             mv_we,
    input logic [WC_W-1:0]  mv_word,
    input logic [IDX_W-1:0] mv_idx,
    input logic             mv_done,
    input logic             mv_abort,
    input logic             mv_active,
    input logic             busy_hit
);

    p_lock_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ctrl_rd && !busy_hit && !cpu_deact && !cpu_tmr_rd)
        |=> (lock_vld && lock_idx == $past(cpu_idx)));

    p_tmr_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_tmr_rd |=> !lock_vld);

    p_busy_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ctrl_rd && busy_hit && !cpu_deact && !cpu_tmr_rd)
        |=> (cpu_code[0] && lock_vld == $past(lock_vld)
             && lock_idx == $past(lock_idx)));

    p_no_write_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mv_we |-> !(lock_vld && lock_idx == mv_idx));

    p_ack_unlocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ack |-> !(lock_vld && lock_idx == rx_idx));

    p_word_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_we && mv_word != '0)
        |-> ($past(mv_we) && $past(mv_word) == mv_word - 1'b1));

    p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mv_done |-> ($past(mv_we) && $past(mv_word) == WC_W'(WORDS - 1)));

    p_deact_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_active && cpu_deact && cpu_idx == mv_idx)
        |=> (mv_abort && !mv_done));

    p_wr_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_active && cpu_data_wr && !cpu_deact && cpu_idx == mv_idx)
        |=> (mv_abort && !mv_done));

    p_single_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mv_done && mv_abort));

    p_ack_drop_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_ack && rx_drop));

endmodule

bind rxmb_guard rxmb_guard_chk #(.NUM_MB(NUM_MB), .WORDS(WORDS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_idx     (cpu_idx),
    .cpu_ctrl_rd (cpu_ctrl_rd),
    .cpu_tmr_rd  (cpu_tmr_rd),
    .cpu_deact   (cpu_deact),
    .cpu_data_wr (cpu_data_wr),
    .cpu_code    (cpu_code),
    .lock_vld    (lock_vld),
    .lock_idx    (lock_idx),
    .rx_idx      (rx_idx),
    .rx_ack      (rx_ack),
    .rx_drop     (rx_drop),
    .mv_we       (mv_we),
    .mv_word     (mv_word),
    .mv_idx      (mv_idx),
    .mv_done     (mv_done),
    .mv_abort    (mv_abort),
    .mv_active   (mv_active),
    .busy_hit    (busy_hit)
);

// File: tb/rxmb_guard_tb_top.sv
// Bench: lock vector table, then directed move, collision and reset tests.
module rxmb_guard_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int OP_RD = 0, OP_TMR = 1, OP_DEACT = 2, OP_ARM = 3;

    typedef struct packed {
        logic [1:0] op;
        logic [3:0] idx;
        logic       lv;
        logic [3:0] li;
        logic [2:0] code;
    } vec_t;

    // op, idx, expected lock valid, expected lock index, expected code
    localparam vec_t VECS [10] = '{
        '{2'd0, 4'd3, 1'b1, 4'd3, 3'd0},
        '{2'd0, 4'd5, 1'b1, 4'd5, 3'd0},
        '{2'd1, 4'd0, 1'b0, 4'd0, 3'd0},
        '{2'd0, 4'd7, 1'b1, 4'd7, 3'd0},
        '{2'd2, 4'd2, 1'b1, 4'd7, 3'd0},
        '{2'd0, 4'd2, 1'b1, 4'd2, 3'd6},
        '{2'd2, 4'd2, 1'b0, 4'd0, 3'd6},
        '{2'd3, 4'd2, 1'b0, 4'd0, 3'd6},
        '{2'd0, 4'd2, 1'b1, 4'd2, 3'd0},
        '{2'd1, 4'd0, 1'b0, 4'd0, 3'd0}
    };

    logic       clk = 1'b0, rst_n = 1'b0;
    logic [3:0] cpu_idx = '0, rx_idx = '0;
    logic       cpu_ctrl_rd = 0, cpu_tmr_rd = 0, cpu_deact = 0, cpu_arm = 0;
    logic       cpu_data_wr = 0, rx_req = 0;
    logic [2:0] cpu_code;
    logic       lock_vld, rx_ack, rx_drop, mv_we, mv_done, mv_abort;
    logic [3:0] lock_idx, mv_idx;
    logic [1:0] mv_word;
    int         n_chk = 0, n_err = 0;

    rxmb_guard #(.NUM_MB(16), .WORDS(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_idx(cpu_idx), .cpu_ctrl_rd(cpu_ctrl_rd),
        .cpu_tmr_rd(cpu_tmr_rd), .cpu_deact(cpu_deact), .cpu_arm(cpu_arm),
        .cpu_data_wr(cpu_data_wr), .cpu_code(cpu_code), .lock_vld(lock_vld),
        .lock_idx(lock_idx), .rx_req(rx_req), .rx_idx(rx_idx), .rx_ack(rx_ack),
        .rx_drop(rx_drop), .mv_we(mv_we), .mv_word(mv_word), .mv_idx(mv_idx),
        .mv_done(mv_done), .mv_abort(mv_abort)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One-cycle CPU strobe; returns at the negedge after it took effect.
    task automatic do_op(input int op, input logic [3:0] idx);
        @(negedge clk);
        cpu_idx     = idx;
        cpu_ctrl_rd = (op == OP_RD);
        cpu_tmr_rd  = (op == OP_TMR);
        cpu_deact   = (op == OP_DEACT);
        cpu_arm     = (op == OP_ARM);
        @(negedge clk);
        {cpu_ctrl_rd, cpu_tmr_rd, cpu_deact, cpu_arm} = '0;
    endtask

    // Present a request that must be accepted; returns at first word cycle.
    task automatic start_move(input logic [3:0] idx, input string req);
        @(negedge clk);
        rx_req = 1'b1;
        rx_idx = idx;
        #1 check(req, rx_ack, 1);
        @(negedge clk);
        rx_req = 1'b0;
    endtask

    task automatic wait_done(input string req);
        for (int k = 0; k < 10; k++) begin
            if (mv_done) break;
            @(negedge clk);
        end
        check(req, mv_done, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 lock_vld", lock_vld, 0);
        check("R1 code", cpu_code, 0);
        check("R1 mv_we", mv_we, 0);
        check("R1 done/abort", {mv_done, mv_abort}, 0);
        check("R1 ack/drop", {rx_ack, rx_drop}, 0);

        // Lock table: R2 code, R3 lock movement, R4 release, R12 re-arm
        for (int i = 0; i < 10; i++) begin
            do_op(int'(VECS[i].op), VECS[i].idx);
            check("R3 table lock_vld", lock_vld, VECS[i].lv);
            if (VECS[i].lv) check("R3 table lock_idx", lock_idx, VECS[i].li);
            check("R2 table code", cpu_code, VECS[i].code);
        end

        // R7 word sequence into empty mailbox 4, R8 empty->full
        start_move(4'd4, "R7 ack");
        for (int w = 0; w < 4; w++) begin
            if (w > 0) @(negedge clk);
            check("R7 we", mv_we, 1);
            check("R7 word", mv_word, w);
            check("R7 idx", mv_idx, 4);
        end
        @(negedge clk);
        check("R7 done", mv_done, 1);
        check("R7 we off", mv_we, 0);
        do_op(OP_RD, 4'd4);
        check("R8 full code", cpu_code, 3'b010);

        // R6 request held while mailbox 4 locked, released by timer read
        @(negedge clk);
        rx_req = 1'b1;
        rx_idx = 4'd4;
        for (int k = 0; k < 3; k++) begin
            #1 check("R6 held ack", rx_ack, 0);
            check("R6 held we", mv_we, 0);
            @(negedge clk);
        end
        cpu_tmr_rd = 1'b1;
        #1 check("R6 ack same cycle as release", rx_ack, 0);
        @(negedge clk);
        cpu_tmr_rd = 1'b0;
        #1 check("R4 released", lock_vld, 0);
        check("R6 ack after release", rx_ack, 1);
        @(negedge clk);
        rx_req = 1'b0;
        wait_done("R6 move done");
        do_op(OP_RD, 4'd4);
        check("R8 overrun code", cpu_code, 3'b100);
        do_op(OP_TMR, 4'd0);

        // R5 busy read during move, lock stays on mailbox 1
        do_op(OP_RD, 4'd1);
        start_move(4'd6, "R5 ack");
        cpu_ctrl_rd = 1'b1;
        cpu_idx     = 4'd6;
        @(negedge clk);
        cpu_ctrl_rd = 1'b0;
        check("R5 busy code", cpu_code, 3'b001);
        check("R5 lock kept vld", lock_vld, 1);
        check("R5 lock kept idx", lock_idx, 1);
        wait_done("R5 move done");
        do_op(OP_TMR, 4'd0);

        // R9 deactivate during move
        start_move(4'd8, "R9 ack");
        cpu_deact = 1'b1;
        cpu_idx   = 4'd8;
        @(negedge clk);
        cpu_deact = 1'b0;
        check("R9 abort", mv_abort, 1);
        check("R9 no done", mv_done, 0);
        check("R9 we stopped", mv_we, 0);
        @(negedge clk);
        check("R9 still no done", mv_done, 0);
        do_op(OP_RD, 4'd8);
        check("R9 inactive code", cpu_code, 3'b110);
        do_op(OP_ARM, 4'd8);
        do_op(OP_TMR, 4'd0);

        // R10 data write during move
        start_move(4'd9, "R10 ack");
        cpu_data_wr = 1'b1;
        cpu_idx     = 4'd9;
        @(negedge clk);
        cpu_data_wr = 1'b0;
        check("R10 abort", mv_abort, 1);
        check("R10 no done", mv_done, 0);
        do_op(OP_RD, 4'd9);
        check("R10 full code", cpu_code, 3'b010);

        // R11 deactivate locked mailbox 10 with a held request
        do_op(OP_RD, 4'd10);
        @(negedge clk);
        rx_req = 1'b1;
        rx_idx = 4'd10;
        #1 check("R11 held", rx_ack, 0);
        @(negedge clk);
        cpu_deact = 1'b1;
        cpu_idx   = 4'd10;
        #1 check("R11 no ack at deact", rx_ack, 0);
        @(negedge clk);
        cpu_deact = 1'b0;
        #1 check("R11 lock cleared", lock_vld, 0);
        check("R11 drop", rx_drop, 1);
        check("R11 no ack", rx_ack, 0);
        @(negedge clk);
        rx_req = 1'b0;
        check("R11 no write", mv_we, 0);

        // R12 re-arm then accept
        do_op(OP_ARM, 4'd10);
        start_move(4'd10, "R12 ack after re-arm");
        wait_done("R12 done");
        do_op(OP_RD, 4'd10);
        check("R12 full code", cpu_code, 3'b010);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule